// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects 32 level-sensitive interrupt requests from peripherals and steers each one onto one of eight CPU interrupt lines. Software enables sources through a global mask word, observes the raw request levels through a read-only status word, and chooses each source's destination through a 4-bit routing field. A CPU line is raised while at least one enabled, active source is steered to it. The line falls on its own once every such source has dropped its request or has been masked.

The block sits on a simple 32-bit register bus. The bus has a request strobe, a write enable, a byte address, write data, and registered read data with a valid flag. The register window is 0x20 bytes. Request inputs are synchronised before they are used. Each CPU line is driven from a flop.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset the mask word is 0, all four routing words are 0, every `irq_o` bit is 0 and `rvalid_o` is 0.
- R2: The mask word at byte offset 0x00 can be written and read back in full. Bit n set to 1 enables source n.
- R3: The status word at offset 0x04 returns the source levels after a 2-stage synchroniser. Writes to 0x04 change neither the status word nor the mask word.
- R4: The routing words at 0x08, 0x0C, 0x10 and 0x14 can be written and read back. Source n is held in the word at 0x14 - 4*(n/8), in bits [4*(n%8)+3 : 4*(n%8)].
- R5: `irq_o[l]` is 1 when some source n has a synchronised level of 1, mask bit 1, and routing value l (0 to 7).
- R6: A source whose routing value is 8 to 15 drives no CPU line.
- R7: A source whose mask bit is 0 drives no CPU line, whatever its level.
- R8: `irq_o` changes on the clock edge after the edge that updates the mask or a routing word. A change on `src_i` reaches `irq_o` on the third clock edge after it is applied.
- R9: A read request (`req_i`=1, `we_i`=0) raises `rvalid_o` for one cycle on the next clock edge, with `rdata_o` valid in that cycle. Reads of 0x18 and 0x1C return 0.
- R10: Several sources may share one line. The line stays high until the last of them goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Peripheral interrupt request levels |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rvalid_o is 1 |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 8 | CPU interrupt lines |

## Verification
Each result has a fixed latency:
- Register contents appear in `rdata_o` one edge after the read request.
- Mask and routing changes reach `irq_o` one edge after the write edge.
- A request level needs three edges: two synchroniser stages and the output flop.

The bench drives all stimulus on falling edges and samples on falling edges. In the latency tests it checks that `irq_o` still holds the old value one sample before the due edge and the new value at that edge. The table-driven cases wait four cycles before sampling, so they check only steady-state routing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DW           = 32;
  localparam int unsigned FLD_W        = 4;
  localparam int unsigned SRC_N        = 32;
  localparam int unsigned LINE_N       = 8;
  localparam int unsigned SRC_PER_WORD = DW / FLD_W;
  localparam int unsigned RWORD_N      = SRC_N / SRC_PER_WORD;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned IDX_W        = ADDR_W - 2;
  // word indices inside the window
  localparam int unsigned MASK_IDX     = 0;
  localparam int unsigned STAT_IDX     = 1;
  localparam int unsigned ROUTE_IDX0   = 2;

  typedef logic [FLD_W-1:0] route_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [SRC_N-1:0]       lvl_i,
  output logic [SRC_N-1:0]       mask_o,
  output route_t [SRC_N-1:0]     route_o,
  output logic [DW-1:0]          rdata_o,
  output logic                   rvalid_o
);
  logic wr, rd;
  logic [SRC_N-1:0]   mask_q;
  route_t [SRC_N-1:0] route_q;
  logic [DW-1:0]      rword [RWORD_N];
  logic [DW-1:0]      rmux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mask_q <= '0;
    else if (wr && idx_i == IDX_W'(MASK_IDX))  mask_q <= wdata_i[SRC_N-1:0];
  end

  // routing words are stored in reverse: the highest word holds sources 0..7
  for (genvar k = 0; k < RWORD_N; k++) begin : g_rword
    localparam int unsigned BASE = (RWORD_N - 1 - k) * SRC_PER_WORD;
    for (genvar j = 0; j < SRC_PER_WORD; j++) begin : g_fld
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          route_q[BASE+j] <= '0;
        else if (wr && idx_i == IDX_W'(ROUTE_IDX0 + k))
          route_q[BASE+j] <= wdata_i[j*FLD_W +: FLD_W];
      end
      assign rword[k][j*FLD_W +: FLD_W] = route_q[BASE+j];
    end
  end

  always_comb begin
    rmux = '0;
    if (idx_i == IDX_W'(MASK_IDX)) rmux = DW'(mask_q);
    if (idx_i == IDX_W'(STAT_IDX)) rmux = DW'(lvl_i);
    for (int k = 0; k < int'(RWORD_N); k++)
      if (idx_i == IDX_W'(ROUTE_IDX0 + k)) rmux = rword[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rmux;
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_line_agg.sv
module irq_line_agg
  import irq_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SRC_N-1:0]    pend_i,
  input  route_t [SRC_N-1:0]  route_i,
  output logic [LINE_N-1:0]   irq_o
);
  logic [LINE_N-1:0] irq_d;

  // field values >= LINE_N match no line, so such sources stay unrouted
  always_comb begin
    irq_d = '0;
    for (int l = 0; l < int'(LINE_N); l++)
      for (int n = 0; n < int'(SRC_N); n++)
        if (pend_i[n] && route_i[n] == FLD_W'(l)) irq_d[l] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic [LINE_N-1:0] irq_o
);
  logic [SRC_N-1:0]   sync_lvl;
  logic [SRC_N-1:0]   mask_q;
  route_t [SRC_N-1:0] route_q;
  logic               unused_addr;

  assign unused_addr = ^addr_i[1:0];

  irq_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_lvl)
  );

  irq_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .idx_i   (addr_i[ADDR_W-1:2]),
    .wdata_i (wdata_i),
    .lvl_i   (sync_lvl),
    .mask_o  (mask_q),
    .route_o (route_q),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  irq_line_agg u_agg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (sync_lvl & mask_q),
    .route_i(route_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     rdata_o,
  input logic              rvalid_o,
  input logic [LINE_N-1:0] irq_o,
  input logic [SRC_N-1:0]  mask_q,
  input logic [SRC_N-1:0]  sync_lvl
);
  // R9
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R9
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:2] >= IDX_W'(ROUTE_IDX0 + RWORD_N)) |=> rdata_o == '0);

  // R3
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:2] == IDX_W'(STAT_IDX)) |=> rdata_o == $past(sync_lvl));

  // R3
  status_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1:2] == IDX_W'(STAT_IDX)) |=> $stable(mask_q));

  // R7
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_q) == '0) |-> irq_o == '0);
endmodule

bind routed_irq_ctrl irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o),
  .irq_o   (irq_o),
  .mask_q  (mask_q),
  .sync_lvl(sync_lvl)
);

// File: tb/tb_routed_irq_ctrl.sv
`timescale 1ns/1ps
module tb_routed_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [7:0]  irq_o;

  int total = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  routed_irq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] w08;
    logic [31:0] w0c;
    logic [31:0] w10;
    logic [31:0] w14;
    logic [31:0] src;
    logic [7:0]  exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000000, 8'h00},
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000001, 8'h01},
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h76543210, 32'h00000088, 8'h88},
    '{32'h00000008, 32'h0, 32'h0, 32'h0, 32'h76543210, 32'h00000088, 8'h08}, // R7
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'hF6543210, 32'h00000081, 8'h01}, // R6
    '{32'hFFFFFFFF, 32'h20000000, 32'h88888888, 32'h88888888, 32'h88888888, 32'h81000000, 8'h05}, // R4 order
    '{32'h00000200, 32'h88888888, 32'h88888888, 32'h88888850, 32'h88888888, 32'h00000300, 8'h20},
    '{32'hFFFFFFFF, 32'h88888888, 32'h88888803, 32'h88888888, 32'h88888888, 32'h00030000, 8'h09},
    '{32'hFFFFFFFF, 32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111, 32'hFFFFFFFF, 8'h02}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o; v = rvalid_o;
    req_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic set_routes(input logic [31:0] a, b, c, d);
    wr(5'h08, a); wr(5'h0C, b); wr(5'h10, c); wr(5'h14, d);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk_i);
    chk("R1 irq_o in reset", 32'(irq_o), 32'h0);
    chk("R1 rvalid_o in reset", 32'(rvalid_o), 32'h0);
    rst_ni = 1'b1;

    rd(5'h00, d, v);
    chk("R1 mask reset", d, 32'h0);
    chk("R9 rvalid after read", 32'(v), 32'h1);
    rd(5'h08, d, v);
    chk("R1 route 0x08 reset", d, 32'h0);
    rd(5'h14, d, v);
    chk("R1 route 0x14 reset", d, 32'h0);
    @(negedge clk_i);
    chk("R9 rvalid single cycle", 32'(rvalid_o), 32'h0);

    // table of routing cases (R5)
    for (int i = 0; i < NVEC; i++) begin
      wr(5'h00, VECS[i].mask);
      set_routes(VECS[i].w08, VECS[i].w0c, VECS[i].w10, VECS[i].w14);
      @(negedge clk_i);
      src_i = VECS[i].src;
      settle();
      chk($sformatf("R5 vector %0d", i), 32'(irq_o), 32'(VECS[i].exp));
    end

    // R2 mask readback
    wr(5'h00, 32'hA5A55A5A);
    rd(5'h00, d, v);
    chk("R2 mask readback", d, 32'hA5A55A5A);

    // R4 route readback
    wr(5'h14, 32'h12345678);
    rd(5'h14, d, v);
    chk("R4 route 0x14 readback", d, 32'h12345678);
    wr(5'h0C, 32'h9ABCDEF0);
    rd(5'h0C, d, v);
    chk("R4 route 0x0C readback", d, 32'h9ABCDEF0);

    // R3 status and ignored write
    @(negedge clk_i);
    src_i = 32'hDEADBEEF;
    settle();
    rd(5'h04, d, v);
    chk("R3 status levels", d, 32'hDEADBEEF);
    wr(5'h04, 32'h00000000);
    rd(5'h04, d, v);
    chk("R3 status after write", d, 32'hDEADBEEF);
    rd(5'h00, d, v);
    chk("R3 mask untouched by status write", d, 32'hA5A55A5A);

    // R9 unused offsets
    rd(5'h18, d, v);
    chk("R9 read 0x18", d, 32'h0);
    rd(5'h1C, d, v);
    chk("R9 read 0x1C", d, 32'h0);

    // R6 unrouted values 8 and 15
    set_routes(32'h88888888, 32'h88888888, 32'h88888888, 32'h8888888F);
    wr(5'h00, 32'hFFFFFFFF);
    @(negedge clk_i);
    src_i = 32'hFFFFFFFF;
    settle();
    chk("R6 unrouted sources", 32'(irq_o), 32'h0);

    // R7 masked source
    wr(5'h14, 32'h88888880);
    wr(5'h00, 32'hFFFFFFFE);
    @(negedge clk_i);
    src_i = 32'h00000001;
    settle();
    chk("R7 masked source", 32'(irq_o), 32'h0);

    // R8 latency from src_i
    wr(5'h00, 32'h00000001);
    @(negedge clk_i);
    src_i = 32'h0;
    settle();
    src_i = 32'h00000001;
    repeat (2) @(negedge clk_i);
    chk("R8 src edge 2 still low", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    chk("R8 src edge 3 high", 32'(irq_o), 32'h01);

    // R8 latency from mask write
    wr(5'h00, 32'h0);
    chk("R8 mask write edge holds", 32'(irq_o), 32'h01);
    @(negedge clk_i);
    chk("R8 mask write next edge", 32'(irq_o), 32'h0);

    // R8 latency from route write
    wr(5'h00, 32'h00000001);
    settle();
    wr(5'h14, 32'h88888883);
    chk("R8 route write edge holds", 32'(irq_o), 32'h01);
    @(negedge clk_i);
    chk("R8 route write next edge", 32'(irq_o), 32'h08);

    // R10 shared line stays until last source drops
    wr(5'h14, 32'h88888800);
    wr(5'h00, 32'hFFFFFFFF);
    @(negedge clk_i);
    src_i = 32'h00000003;
    settle();
    chk("R10 both high", 32'(irq_o), 32'h01);
    src_i = 32'h00000002;
    settle();
    chk("R10 one remains", 32'(irq_o), 32'h01);
    src_i = 32'h00000000;
    settle();
    chk("R10 all dropped", 32'(irq_o), 32'h0);

    finish_run();
  end
endmodule